// File: doc/BRIEF.md
# Rotating Interrupt Priority Resolver

This block is the arbitration core of an eight-line programmable interrupt controller. It captures rising edges on the incoming interrupt lines into a request register, masks them, and searches for the best candidate in an order that is rotated by a 3-bit offset. It compares that candidate with the highest level currently in service and raises a request to the processor only when the candidate is strictly more urgent. The raise flag and the chosen line number are combinational from the registers.

When the processor acknowledges a line, the block clears that line's request bit. It also either marks the line as in service or, in automatic end-of-interrupt mode, leaves the in-service register alone and may rotate priority so the acknowledged line becomes the least urgent. A neighbouring command block drives the mask, the mode flags, explicit offset loads and in-service clears. On a cascade master, a nested-mode flag can leave the cascade input (line 2) out of the in-service comparison.

Top module: `irq_prio_core`

## Requirements
- R1: A request bit becomes 1 on the clock edge after its input line goes from 0 to 1. A line that is held at 1 does not set its request bit again.
- R2: Only request bits whose mask bit is 0 take part in arbitration. A masked request never causes `raise`.
- R3: Priority level p belongs to line (p + `offset_q`) mod 8, and level 0 is the most urgent. When `raise` is 1, `raise_line` is the line of the most urgent candidate.
- R4: When no unmasked request exists, `raise` is 0.
- R5: `raise` is 1 only when the best candidate level is strictly lower than the most urgent in-service level, found by the same rotated search. An empty in-service register counts as level 8.
- R6: With `nested_en` and `is_master` both 1, in-service bit 2 is left out of the current-level search. With either flag at 0, it is included.
- R7: An acknowledge clears the request bit of `ack_line`. A rising edge on that line in the same cycle leaves the bit set.
- R8: An acknowledge with `auto_eoi`=0 sets the in-service bit of `ack_line`. With `auto_eoi`=1 the in-service register is unchanged.
- R9: An acknowledge with `auto_eoi`=1 and `rot_aeoi`=1 sets `offset_q` to (`ack_line` + 1) mod 8. With `rot_aeoi`=0 the offset is unchanged.
- R10: `offset_ld` loads `offset_val` into `offset_q` and takes precedence over an automatic rotation in the same cycle. Each 1 bit of `isr_clr` clears the matching in-service bit.
- R11: After reset, the request, in-service, previous-level and offset registers are all zero and `raise` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| line_in | input | 8 | Interrupt input lines |
| mask_i | input | 8 | Mask bits, 1 blocks the line |
| nested_en | input | 1 | Special fully nested mode |
| is_master | input | 1 | This controller is the cascade master |
| auto_eoi | input | 1 | Automatic end of interrupt on acknowledge |
| rot_aeoi | input | 1 | Rotate priority on automatic end of interrupt |
| ack_i | input | 1 | Single-cycle acknowledge strobe |
| ack_line | input | 3 | Line being acknowledged |
| isr_clr | input | 8 | In-service bits to clear this cycle |
| offset_ld | input | 1 | Load the rotation offset |
| offset_val | input | 3 | Offset value to load |
| raise | output | 1 | Interrupt request to the processor |
| raise_line | output | 3 | Line chosen for the request |
| req_q | output | 8 | Request register |
| insvc_q | output | 8 | In-service register |
| offset_q | output | 3 | Current rotation offset |

## Verification
A wrong rotation offset or a misindexed search shows up at once as the wrong `raise_line` for a pair of competing lines. For this reason the vectors place two requests at different offsets, so that the winner changes as the rotation changes. A stale in-service bit or a missed acknowledge clear shows up one clock after the acknowledge: `raise` either stays blocked for a more urgent line or fires again for a line that was already serviced. The nested-mode case is checked with an equal-level cascade request, where only the exclusion of bit 2 changes `raise`.

// File: rtl/irq_prio_core.sv
module irq_prio_core (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [7:0] line_in,
  input  logic [7:0] mask_i,
  input  logic       nested_en,
  input  logic       is_master,
  input  logic       auto_eoi,
  input  logic       rot_aeoi,
  input  logic       ack_i,
  input  logic [2:0] ack_line,
  input  logic [7:0] isr_clr,
  input  logic       offset_ld,
  input  logic [2:0] offset_val,
  output logic       raise,
  output logic [2:0] raise_line,
  output logic [7:0] req_q,
  output logic [7:0] insvc_q,
  output logic [2:0] offset_q
);

  logic [7:0] last_q;
  logic [7:0] edge_hit, ack_bit, cand, cur_set;
  logic [3:0] cand_lvl, cur_lvl;

  function automatic logic [3:0] find_lvl(input logic [7:0] v, input logic [2:0] off);
    logic [2:0] idx;
    find_lvl = 4'd8;
    for (int p = 7; p >= 0; p--) begin
      idx = 3'(p) + off;
      if (v[idx]) find_lvl = 4'(p);
    end
  endfunction

  assign edge_hit = line_in & ~last_q;
  assign ack_bit  = ack_i ? (8'd1 << ack_line) : 8'd0;
  assign cand     = req_q & ~mask_i;
  assign cur_set  = (nested_en && is_master) ? (insvc_q & 8'hFB) : insvc_q;
  assign cand_lvl = find_lvl(cand, offset_q);
  assign cur_lvl  = find_lvl(cur_set, offset_q);
  assign raise    = cand_lvl < cur_lvl;
  assign raise_line = cand_lvl[2:0] + offset_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      last_q   <= '0;
      req_q    <= '0;
      insvc_q  <= '0;
      offset_q <= '0;
    end else begin
      last_q  <= line_in;
      req_q   <= (req_q & ~ack_bit) | edge_hit;
      insvc_q <= (insvc_q & ~isr_clr) | (auto_eoi ? 8'd0 : ack_bit);
      if (offset_ld)
        offset_q <= offset_val;
      else if (ack_i && auto_eoi && rot_aeoi)
        offset_q <= ack_line + 3'd1;
    end
  end

endmodule

module irq_prio_core_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [7:0] line_in,
  input logic [7:0] mask_i,
  input logic       auto_eoi,
  input logic       rot_aeoi,
  input logic       ack_i,
  input logic [2:0] ack_line,
  input logic [7:0] isr_clr,
  input logic       offset_ld,
  input logic       raise,
  input logic [2:0] raise_line,
  input logic [7:0] req_q,
  input logic [7:0] insvc_q,
  input logic [2:0] offset_q,
  input logic [7:0] last_q
);

  a_r1_edge_sets: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((req_q & $past(line_in & ~last_q)) == $past(line_in & ~last_q)));

  a_r2_unmasked_winner: assert property (@(posedge clk) disable iff (!rst_n)
    raise |-> (req_q[raise_line] && !mask_i[raise_line]));

  a_r4_none_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    ((req_q & ~mask_i) == 8'd0) |-> !raise);

  a_r7_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_i && !(line_in[ack_line] && !last_q[ack_line])) |=> !req_q[$past(ack_line)]);

  a_r8_isr_set: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_i && !auto_eoi && !isr_clr[ack_line]) |=> insvc_q[$past(ack_line)]);

  a_r9_rotate: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_i && auto_eoi && rot_aeoi && !offset_ld) |=> (offset_q == $past(ack_line) + 3'd1));

endmodule

bind irq_prio_core irq_prio_core_chk u_chk (.*);

// File: tb/sim_irq_prio_core.sv
module sim_irq_prio_core;

  logic clk = 1'b0;
  logic rst_n;
  logic [7:0] line_in, mask_i, isr_clr;
  logic nested_en, is_master, auto_eoi, rot_aeoi, ack_i, offset_ld;
  logic [2:0] ack_line, offset_val;
  logic raise;
  logic [2:0] raise_line, offset_q;
  logic [7:0] req_q, insvc_q;

  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  irq_prio_core u0 (.*);

  // {offset, mask, line pattern, expected raise, expected line}
  localparam logic [22:0] VEC [10] = '{
    {3'd0, 8'h00, 8'h00, 1'b0, 3'd0},
    {3'd0, 8'h00, 8'h81, 1'b1, 3'd0},
    {3'd0, 8'h01, 8'h81, 1'b1, 3'd7},
    {3'd3, 8'h00, 8'h81, 1'b1, 3'd7},
    {3'd7, 8'h00, 8'h81, 1'b1, 3'd7},
    {3'd1, 8'h00, 8'h81, 1'b1, 3'd7},
    {3'd5, 8'h00, 8'h24, 1'b1, 3'd5},
    {3'd6, 8'h00, 8'h24, 1'b1, 3'd2},
    {3'd0, 8'hFF, 8'hFF, 1'b0, 3'd0},
    {3'd2, 8'h04, 8'h0C, 1'b1, 3'd3}
  };

  task automatic check(input string tag, input int got, input int exp);
    n_chk++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0; line_in = '0; mask_i = '0; isr_clr = '0;
    nested_en = 0; is_master = 0; auto_eoi = 0; rot_aeoi = 0;
    ack_i = 0; ack_line = '0; offset_ld = 0; offset_val = '0;
    tick(); tick();
    rst_n = 1'b1;
    tick();
  endtask

  task automatic pulse(input int ln);
    line_in[ln] = 1'b1; tick();
    line_in[ln] = 1'b0; tick();
  endtask

  task automatic ack(input int ln, input logic ae, input logic rot);
    ack_i = 1'b1; ack_line = 3'(ln); auto_eoi = ae; rot_aeoi = rot;
    tick();
    ack_i = 1'b0; auto_eoi = 0; rot_aeoi = 0;
  endtask

  initial begin
    #200000;
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    do_reset();
    check("R11 req", req_q, 0);
    check("R11 insvc", insvc_q, 0);
    check("R11 offset", offset_q, 0);
    check("R11 raise", raise, 0);

    // R2 R3 R4: rotated arbitration vectors
    for (int i = 0; i < 10; i++) begin
      do_reset();
      offset_ld = 1'b1; offset_val = VEC[i][22:20]; tick(); offset_ld = 1'b0;
      mask_i = VEC[i][19:12];
      line_in = VEC[i][11:4]; tick();
      line_in = '0; tick();
      check("R3 vec raise", raise, VEC[i][3]);
      if (VEC[i][3]) check("R3 vec line", raise_line, VEC[i][2:0]);
    end

    // R1 R7 R8: acknowledge and level hold
    do_reset();
    line_in[3] = 1'b1; tick(); tick();
    check("R1 edge set", req_q, 8'h08);
    check("R3 line3", raise_line, 3);
    ack(3, 0, 0);
    check("R7 req cleared", req_q, 0);
    check("R8 isr set", insvc_q, 8'h08);
    tick(); tick();
    check("R1 held level no reset", req_q, 0);
    check("R4 no cand", raise, 0);

    // R5: in-service blocking
    pulse(5);
    check("R5 lower blocked", raise, 0);
    pulse(1);
    check("R5 higher raised", raise, 1);
    check("R5 higher line", raise_line, 1);
    line_in[3] = 1'b0; tick();
    line_in[3] = 1'b1; tick();
    mask_i = 8'h02; tick();
    check("R5 equal level blocked", raise, 0);

    // R6: nested-mode exclusion of line 2
    do_reset();
    pulse(2);
    ack(2, 0, 0);
    pulse(2);
    check("R6 off blocked", raise, 0);
    nested_en = 1; is_master = 1; tick();
    check("R6 nested raise", raise, 1);
    check("R6 nested line", raise_line, 2);
    is_master = 0; tick();
    check("R6 slave blocked", raise, 0);
    nested_en = 0;
    isr_clr = 8'h04; tick(); isr_clr = '0;
    check("R10 isr cleared", insvc_q, 0);
    check("R10 raise after clear", raise, 1);

    // R8 R9: auto end of interrupt
    do_reset();
    pulse(4);
    ack(4, 1, 1);
    check("R9 rotate offset", offset_q, 5);
    check("R8 aeoi isr untouched", insvc_q, 0);
    check("R7 aeoi req cleared", req_q, 0);
    pulse(1);
    ack(1, 1, 0);
    check("R9 no rotate", offset_q, 5);
    ack(7, 1, 1);
    check("R9 wrap", offset_q, 0);

    // R10: load beats rotation
    offset_ld = 1'b1; offset_val = 3'd6;
    ack(0, 1, 1);
    offset_ld = 1'b0;
    check("R10 load wins", offset_q, 6);

    // R7: edge in the same cycle as acknowledge
    do_reset();
    line_in[6] = 1'b1;
    ack(6, 0, 0);
    check("R7 edge wins", req_q[6], 1);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule